// File: doc/BRIEF.md
# Interrupt Status and Clear Register Block

This block collects the event pulses that a two-wire bus master engine raises and turns them into a single interrupt request. Twelve sources are held in a raw status register. A mask register selects which of them may reach the interrupt line. A masked status view shows the raw bits that the mask lets through. Software acknowledges a source by reading that source's private clear address. The read returns the bit and clears that bit alone, so events that arrive between a status read and the acknowledge are not lost. A second address clears every source with one read.

When the engine gives up a transfer, it pulses the abort source together with a vector of reasons. The reasons build up in an abort-reason register until software reads the abort source's clear address or the combined clear address. That read clears the abort interrupt bit and the reason register at the same edge. The register port is a plain strobe interface, and read data arrives one cycle after the strobe.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset, the raw status, mask, masked status and abort-reason registers read as zero, and irq_o is low.
- R2: A pulse on evt_i[k] sets raw bit k. The bit holds until it is cleared. The raw status register is read at word address 2, with its bits in positions 11..0. The bit order is: 0 receive underflow, 1 receive overflow, 2 receive threshold, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 bus activity, 9 stop seen, 10 start seen, 11 general call.
- R3: The mask register sits at word address 0. It is read/write and holds wdata bits 11..0. Word address 1 returns raw status AND mask.
- R4: irq_o is high exactly when some bit is set in both the raw status register and the mask. It reflects an event, or a mask write, in the cycle that follows the clock edge at which it was taken.
- R5: A read of word address 8+k (k = 0..11) returns raw bit k in data bit 0, with zeros above it. The same read clears raw bit k and leaves every other raw bit unchanged.
- R6: A read of word address 14, which clears the transmit abort bit, also clears the abort-reason register at the same edge.
- R7: abt_why_i is sampled only when evt_i[6] is high. Its bits are then ORed into the 13-bit abort-reason register, which is read at word address 4 in bits 12..0. The reason bits are: 0 seven-bit address not acknowledged, 1 first ten-bit address byte not acknowledged, 2 second ten-bit address byte not acknowledged, 3 data not acknowledged, 4 general call not acknowledged, 5 read after general call, 7 start byte acknowledged, 9 start byte with restart disabled, 10 ten-bit read with restart disabled, 11 master disabled, 12 arbitration lost.
- R8: A read of word address 3 returns the raw status. The same read clears all raw bits and the abort-reason register.
- R9: An event, or an abort reason, that arrives in the same cycle as a read that clears it leaves that bit set.
- R10: Writing 0 to the mask drops irq_o but keeps every raw bit. Writing the mask back raises irq_o again.
- R11: Writes to any address other than 0 change no register. Reads of addresses 0, 1, 2 and 4 clear nothing.
- R12: Read data is valid in the cycle after the read strobe. It holds until the next read. Reads of unmapped addresses (5 to 7, and 20 and above) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 12 | One-cycle event pulses, one per source |
| abt_why_i | input | 13 | Abort reason bits, qualified by evt_i[6] |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 for a write, 0 for a read |
| reg_addr_i | input | 6 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register here is a single flop stage, so each result is due exactly one edge after the cycle that caused it. Read data, clears, event capture and the interrupt level all appear after the first rising edge. The bench drives every input on the falling edge and samples outputs on the next falling edge, one rising edge later. It computes the expected read value from its model state before the edge, and the expected interrupt level from the state after the edge. Same-cycle event and clear collisions therefore line up exactly, as R9 requires.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int NUM_SRC   = 12;
  localparam int NUM_WHY   = 13;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;
  localparam int A_MASK    = 0;
  localparam int A_STAT    = 1;
  localparam int A_RAW     = 2;
  localparam int A_CLR_ALL = 3;
  localparam int A_WHY     = 4;
  localparam int A_CLR_0   = 8;
  localparam int SRC_ABT   = 6;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_REG  = 2'd1,
    RD_BIT  = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_regs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_en_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] sel_src_o,
  output logic [NUM_SRC-1:0] clr_src_o,
  output logic               clr_why_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic rd, wr, hit_all;

  assign rd      = reg_en_i & ~reg_we_i;
  assign wr      = reg_en_i &  reg_we_i;
  assign hit_all = (reg_addr_i == ADDR_W'(A_CLR_ALL));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_sel
    assign sel_src_o[k] = (reg_addr_i == ADDR_W'(A_CLR_0 + k));
    assign clr_src_o[k] = rd & (sel_src_o[k] | hit_all);
  end

  assign clr_why_o = clr_src_o[SRC_ABT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  mask_o <= '0;
    else if (wr && reg_addr_i == ADDR_W'(A_MASK)) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch
  import irq_regs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_WHY-1:0] why_i,
  input  logic [NUM_SRC-1:0] clr_src_i,
  input  logic               clr_why_i,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_WHY-1:0] why_o
);
  // set dominates clear: a colliding event is kept
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_raw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          raw_o[k] <= 1'b0;
      else if (evt_i[k])    raw_o[k] <= 1'b1;
      else if (clr_src_i[k]) raw_o[k] <= 1'b0;
    end
  end

  logic [NUM_WHY-1:0] why_set;
  assign why_set = evt_i[SRC_ABT] ? why_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        why_o <= '0;
    else if (clr_why_i) why_o <= why_set;
    else                why_o <= why_o | why_set;
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_regs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_en_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] sel_src_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_WHY-1:0] why_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] rd_val;
  rd_kind_e          kind;

  always_comb begin
    kind   = RD_NONE;
    rd_val = '0;
    if (|sel_src_i) kind = RD_BIT;
    unique case (reg_addr_i)
      ADDR_W'(A_MASK):    begin kind = RD_REG; rd_val = DATA_W'(mask_i); end
      ADDR_W'(A_STAT):    begin kind = RD_REG; rd_val = DATA_W'(raw_i & mask_i); end
      ADDR_W'(A_RAW),
      ADDR_W'(A_CLR_ALL): begin kind = RD_REG; rd_val = DATA_W'(raw_i); end
      ADDR_W'(A_WHY):     begin kind = RD_REG; rd_val = DATA_W'(why_i); end
      default: ;
    endcase
    if (kind == RD_BIT) rd_val = DATA_W'(|(sel_src_i & raw_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rdata_o <= '0;
    else if (reg_en_i && !reg_we_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_regs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_WHY-1:0] abt_why_i,
  input  logic               reg_en_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] sel_src, clr_src, mask_q, raw_q;
  logic [NUM_WHY-1:0] why_q;
  logic               clr_why;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_SRC];

  irq_reg_decode u_dec (
    .clk_i, .rst_ni, .reg_en_i, .reg_we_i, .reg_addr_i,
    .wdata_i   (reg_wdata_i[NUM_SRC-1:0]),
    .sel_src_o (sel_src),
    .clr_src_o (clr_src),
    .clr_why_o (clr_why),
    .mask_o    (mask_q)
  );

  irq_event_latch u_lat (
    .clk_i, .rst_ni, .evt_i,
    .why_i     (abt_why_i),
    .clr_src_i (clr_src),
    .clr_why_i (clr_why),
    .raw_o     (raw_q),
    .why_o     (why_q)
  );

  irq_read_port u_rd (
    .clk_i, .rst_ni, .reg_en_i, .reg_we_i, .reg_addr_i,
    .sel_src_i (sel_src),
    .raw_i     (raw_q),
    .mask_i    (mask_q),
    .why_i     (why_q),
    .rdata_o   (reg_rdata_o)
  );

  assign irq_o = |(raw_q & mask_q);
endmodule

// File: rtl/irq_ctrl_regs_chk.sv
module irq_ctrl_regs_chk
  import irq_regs_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               reg_en_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_WHY-1:0] why_q
);
  logic               rd, wr, src_clr_rd, why_clr_rd;
  logic [NUM_SRC-1:0] one_bit;

  assign rd = reg_en_i & ~reg_we_i;
  assign wr = reg_en_i &  reg_we_i;
  assign src_clr_rd = rd && reg_addr_i >= ADDR_W'(A_CLR_0)
                         && reg_addr_i <  ADDR_W'(A_CLR_0 + NUM_SRC);
  assign why_clr_rd = rd && (reg_addr_i == ADDR_W'(A_CLR_0 + SRC_ABT)
                         ||  reg_addr_i == ADDR_W'(A_CLR_ALL));
  assign one_bit = src_clr_rd ? (NUM_SRC'(1) << (reg_addr_i - ADDR_W'(A_CLR_0))) : '0;

  AST_EVT_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_CLR_ONLY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_clr_rd && evt_i == '0) |=> (raw_q == ($past(raw_q) & ~$past(one_bit)))); // R5

  AST_WHY_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (why_clr_rd && !evt_i[SRC_ABT]) |=> (why_q == '0)); // R6

  AST_WHY_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!why_clr_rd && !evt_i[SRC_ABT]) |=> $stable(why_q)); // R7

  AST_MASK_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i == ADDR_W'(A_MASK) && reg_wdata_i[NUM_SRC-1:0] == '0) |=> !irq_o); // R10

  AST_MASK_KEEPS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (($past(raw_q) & ~raw_q) == '0)); // R10

  AST_NO_WR_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i != ADDR_W'(A_MASK)) |=> $stable(mask_q)); // R11
endmodule

bind irq_ctrl_regs irq_ctrl_regs_chk u_chk (
  .clk_i, .rst_ni, .evt_i, .reg_en_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .irq_o,
  .raw_q  (raw_q),
  .mask_q (mask_q),
  .why_q  (why_q)
);

// File: tb/irq_ctrl_regs_tb.sv
`timescale 1ns/1ps
module irq_ctrl_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] evt_i = '0;
  logic [12:0] abt_why_i = '0;
  logic        reg_en_i = 1'b0, reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [11:0] m_raw = '0, m_mask = '0;
  logic [12:0] m_why = '0;

  always #2 clk_i = ~clk_i;

  irq_ctrl_regs u_dut (.*);

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    if (a == 0) return {20'd0, m_mask};
    if (a == 1) return {20'd0, m_raw & m_mask};
    if (a == 2 || a == 3) return {20'd0, m_raw};
    if (a == 4) return {19'd0, m_why};
    if (a >= 8 && a < 20) return {31'd0, m_raw[a-8]};
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, result sampled at next negedge
  task automatic step(input logic en, input logic we, input logic [5:0] a,
                      input logic [31:0] wd, input logic [11:0] ev,
                      input logic [12:0] why, input string req);
    logic [31:0] e;
    logic [11:0] clr;
    bit rd;
    rd = en && !we;
    e = exp_rd(a);
    clr = '0;
    if (rd && a >= 8 && a < 20) clr[a-8] = 1'b1;
    if (rd && a == 3) clr = '1;
    reg_en_i = en; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    evt_i = ev; abt_why_i = why;
    if (en && we && a == 0) m_mask = wd[11:0];
    m_raw = (m_raw & ~clr) | ev;
    if (clr[6]) m_why = '0;
    if (ev[6]) m_why = m_why | why;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_en_i = 1'b0; reg_we_i = 1'b0; evt_i = '0; abt_why_i = '0;
    if (rd) check(req, reg_rdata_o, e);
    check("R4", {31'd0, irq_o}, {31'd0, |(m_raw & m_mask)});
  endtask

  task automatic rd(input logic [5:0] a, input string req);
    step(1'b1, 1'b0, a, '0, '0, '0, req);
  endtask
  task automatic wr(input logic [5:0] a, input logic [31:0] d, input string req);
    step(1'b1, 1'b1, a, d, '0, '0, req);
  endtask
  task automatic ev(input logic [11:0] e, input logic [12:0] w, input string req);
    step(1'b0, 1'b0, '0, '0, e, w, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R1", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(0, "R1"); rd(1, "R1"); rd(2, "R1"); rd(4, "R1");
    // R2 each event sets its bit
    for (int k = 0; k < 12; k++) begin
      ev(12'(1) << k, '0, "R2");
      rd(2, "R2");
    end
    // R5 clear one bit at a time, others kept
    rd(8 + 3, "R5"); rd(2, "R5");
    rd(8 + 3, "R5");
    rd(8 + 11, "R5"); rd(2, "R5");
    // R3 / R4 mask and masked status
    wr(0, 32'hFFFF_F0A5, "R3"); rd(0, "R3"); rd(1, "R3");
    // R10 mask off keeps raw, mask on restores irq
    wr(0, 0, "R10"); rd(2, "R10"); wr(0, 32'h0FF, "R10"); rd(1, "R10");
    // R11 writes elsewhere do nothing, plain reads clear nothing
    wr(2, 0, "R11"); wr(8 + 4, 0, "R11"); wr(3, 0, "R11"); wr(4, 0, "R11");
    rd(2, "R11"); rd(4, "R11"); rd(0, "R11");
    // R7 abort reasons accumulate, ignored without the abort event
    rd(3, "R8");
    ev(12'h001, 13'h1FFF, "R7"); rd(4, "R7");
    ev(12'h040, 13'h1001, "R7"); ev(12'h040, 13'h0008, "R7"); rd(4, "R7");
    // R6 abort clear clears reasons
    rd(8 + 6, "R6"); rd(4, "R6"); rd(2, "R6");
    // R8 combined clear
    ev(12'hFFF, 13'h0800, "R8"); rd(3, "R8"); rd(2, "R8"); rd(4, "R8");
    // R9 collisions
    step(1'b1, 1'b0, 8 + 5, '0, 12'h020, '0, "R9"); rd(2, "R9");
    step(1'b1, 1'b0, 8 + 6, '0, 12'h040, 13'h0004, "R9"); rd(4, "R9"); rd(2, "R9");
    step(1'b1, 1'b0, 3, '0, 12'h100, '0, "R9"); rd(2, "R9");
    // R12 unmapped reads return zero, data holds while idle
    rd(5, "R12"); rd(7, "R12"); rd(20, "R12"); rd(63, "R12");
    rd(2, "R12"); ev('0, '0, "R12"); check("R12", reg_rdata_o, exp_rd(2));
    // constrained random mix
    for (int i = 0; i < 1500; i++) begin
      logic [5:0] a;
      logic [11:0] e;
      int op;
      op = int'($urandom_range(0, 9));
      e  = ($urandom_range(0, 3) == 0) ? 12'($urandom) : '0;
      case (op)
        0, 1, 2: a = 6'(8 + $urandom_range(0, 11));
        3: a = 3;
        4: a = 6'($urandom_range(0, 4));
        default: a = 6'($urandom);
      endcase
      if (op == 9)
        step(1'b1, 1'b1, ($urandom_range(0, 1) == 0) ? 6'd0 : a, $urandom, e, 13'($urandom), "R3");
      else if (op == 8)
        step(1'b0, 1'b0, a, '0, e, 13'($urandom), "R2");
      else
        step(1'b1, 1'b0, a, '0, e, 13'($urandom), "R9");
    end
    rd(2, "R2"); rd(4, "R7"); rd(0, "R3");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule